// File: doc/BRIEF.md
# Ring Beamformer Stage

This block is one stage of a daisy chain of identical beamforming stages. Each stage takes a stream of real samples from its own converter. It turns every pair of them into one complex baseband sample by mixing at a quarter of the sample rate and decimating by two. It multiplies that sample by a complex weight that can be programmed. It then adds the product to the partial beam sum that arrives from the previous stage and hands the saturated sum on to the next stage. The same module sits at every position of the ring. The first stage is marked as the head through a control bit, which discards whatever arrives on its ring input.

A local filterbank port shows either this stage's own weighted sample or the running ring sum. Tapping at stage k therefore gives either one input on its own or the combined beam of the first k inputs. A second lane carries correlator data from the previous stage to the next one unchanged, with the same latency as the ring sum. A delay that can be programmed in the local path lets the host line up each stage's product with the partial sum that travels the ring. A small register write port loads the weights, the control bits and that delay.

Top module: `rbf_unit`

## Requirements
- R1: After reset the stage counts accepted real samples modulo 4. For samples x0,x1 at counts 0,1 it produces I=x0, Q=-x1. For samples x2,x3 at counts 2,3 it produces I=-x2, Q=x3. This gives one complex sample, 13 bits per part, for every two real samples.
- R2: The weighted sample is Y = W*X. W holds two signed 12-bit parts with 11 fraction bits. Each part of the full-precision product is rounded by adding 1024 and shifting right arithmetically by 11.
- R3: The ring output is the sum of the ring input and the weighted sample, 24-bit signed per part. It saturates to 8388607 or -8388608 and never wraps.
- R4: When control bit 0 (head) is set, the ring input counts as zero whatever its value or valid. The ring output then carries the local weighted sample and is valid whenever that sample is valid.
- R5: Control bit 1 (tap) selects the filterbank port source: 1 gives the ring output sum and its valid, 0 gives the local weighted sample.
- R6: Correlator lane data reappears on the correlator output unchanged, two cycles after it enters, together with its valid.
- R7: The register map is: address 0 is the weight real part, address 1 the weight imaginary part, address 2 the control bits, address 3 the alignment delay. Weight writes go to a staging copy. The staging copy is committed when the first real sample of a pair is accepted. The weight in use therefore never changes between the two samples of a pair. A write issued in the same cycle as, or after, that first sample applies from the next pair.
- R8: The alignment delay d lies between 0 and DLY_DEPTH-1; a larger value written is clamped to DLY_DEPTH-1. The second real sample of a pair is accepted at clock edge e. The weighted sample is added to the ring input that is presented at edge e+2+d. The result appears after edge e+3+d.
- R9: Reset clears every valid output, both weights, both control bits and the delay. Without writes, the ring output therefore equals the ring input and the filterbank port shows zero.
- R10: For a stage that is not the head, the ring output valid follows ring input valid with a fixed latency of two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | Real sample strobe |
| adc_data | input | 12 | Signed real sample |
| ring_in_valid | input | 1 | Partial sum from the previous stage is valid |
| ring_in_re | input | 24 | Partial sum, real part |
| ring_in_im | input | 24 | Partial sum, imaginary part |
| ring_out_valid | output | 1 | Updated sum valid |
| ring_out_re | output | 24 | Updated sum, real part |
| ring_out_im | output | 24 | Updated sum, imaginary part |
| fb_valid | output | 1 | Filterbank port valid |
| fb_re | output | 24 | Filterbank port, real part |
| fb_im | output | 24 | Filterbank port, imaginary part |
| corr_in_valid | input | 1 | Correlator lane valid from the previous stage |
| corr_in_data | input | CORR_W | Correlator lane data from the previous stage |
| corr_out_valid | output | 1 | Correlator lane valid to the next stage |
| corr_out_data | output | CORR_W | Correlator lane data to the next stage |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 12 | Register write data |

## Verification
The bench builds the stage with DLY_DEPTH=8 and CORR_W=16. The shallow delay line lets a single write of 20 show the clamp to 7. With that clamp, a ring sum offset by the full alignment delay still fits inside a short burst. Bursts stream pairs back to back, so the sample-count phase runs through both halves of the mixing sequence. A weight write can then land between the two samples of a pair, and ring values near full scale drive the adder into both saturation limits.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    localparam int SMP_W    = 12;
    localparam int WGT_W    = 12;
    localparam int WGT_FRAC = 11;
    localparam int RING_W   = 24;
    localparam int BB_W     = SMP_W + 1;
    localparam int PROD_W   = BB_W + WGT_W + 1;

    localparam logic signed [RING_W-1:0] RING_MAX = {1'b0, {(RING_W-1){1'b1}}};
    localparam logic signed [RING_W-1:0] RING_MIN = {1'b1, {(RING_W-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(1 << (WGT_FRAC-1));

    typedef struct packed {
        logic signed [BB_W-1:0] re;
        logic signed [BB_W-1:0] im;
    } bb_cplx_t;

    typedef struct packed {
        logic signed [WGT_W-1:0] re;
        logic signed [WGT_W-1:0] im;
    } wgt_t;

    typedef struct packed {
        logic signed [RING_W-1:0] re;
        logic signed [RING_W-1:0] im;
    } ring_cplx_t;

    typedef enum logic [1:0] {
        REG_WGT_RE = 2'd0,
        REG_WGT_IM = 2'd1,
        REG_CTRL   = 2'd2,
        REG_ALIGN  = 2'd3
    } reg_addr_e;

    // Round half up by dropping the weight fraction bits.
    function automatic logic signed [RING_W-1:0] round_prod(input logic signed [PROD_W-1:0] p);
        logic signed [PROD_W-1:0] biased;
        logic signed [PROD_W-1:0] shifted;
        biased  = p + RND_HALF;
        shifted = biased >>> WGT_FRAC;
        return shifted[RING_W-1:0];
    endfunction

    // Add with clamping to the ring range.
    function automatic logic signed [RING_W-1:0] sat_add(input logic signed [RING_W-1:0] a,
                                                         input logic signed [RING_W-1:0] b);
        logic [RING_W:0] s;
        s = {a[RING_W-1], a} + {b[RING_W-1], b};
        if (s[RING_W] != s[RING_W-1])
            return s[RING_W] ? RING_MIN : RING_MAX;
        return s[RING_W-1:0];
    endfunction

endpackage

// File: rtl/rbf_ddc.sv
module rbf_ddc
    import rbf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adc_valid,
    input  logic signed [SMP_W-1:0] adc_data,
    output logic                    pair_start,
    output bb_cplx_t                bb_data,
    output logic                    bb_valid
);
    logic [1:0]              phase;
    logic signed [SMP_W-1:0] held;
    logic signed [BB_W-1:0]  held_x;
    logic signed [BB_W-1:0]  cur_x;

    assign pair_start = adc_valid && !phase[0];
    assign held_x     = BB_W'(held);
    assign cur_x      = BB_W'(adc_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            held     <= '0;
            bb_data  <= '0;
            bb_valid <= 1'b0;
        end else begin
            bb_valid <= 1'b0;
            if (adc_valid) begin
                phase <= phase + 2'd1;
                if (!phase[0]) begin
                    held <= adc_data;
                end else begin
                    // quarter-rate mixer folded with a two-tap decimator
                    bb_data.re <= phase[1] ? -held_x : held_x;
                    bb_data.im <= phase[1] ? cur_x : -cur_x;
                    bb_valid   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rbf_cfg.sv
module rbf_cfg
    import rbf_pkg::*;
#(
    parameter int DLY_DEPTH = 16,
    localparam int DLY_AW   = (DLY_DEPTH > 1) ? $clog2(DLY_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WGT_W-1:0]  cfg_wdata,
    input  logic              pair_start,
    output wgt_t              wgt_active,
    output logic              head,
    output logic              tap_ring,
    output logic [DLY_AW-1:0] align
);
    localparam logic [WGT_W-1:0]  ALIGN_LIM  = WGT_W'(DLY_DEPTH - 1);
    localparam logic [DLY_AW-1:0] ALIGN_CLIP = DLY_AW'(DLY_DEPTH - 1);

    wgt_t wgt_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_stage  <= '0;
            wgt_active <= '0;
            head       <= 1'b0;
            tap_ring   <= 1'b0;
            align      <= '0;
        end else begin
            if (cfg_we) begin
                case (reg_addr_e'(cfg_addr))
                    REG_WGT_RE: wgt_stage.re <= cfg_wdata;
                    REG_WGT_IM: wgt_stage.im <= cfg_wdata;
                    REG_CTRL: begin
                        head     <= cfg_wdata[0];
                        tap_ring <= cfg_wdata[1];
                    end
                    REG_ALIGN:
                        align <= (cfg_wdata > ALIGN_LIM) ? ALIGN_CLIP : cfg_wdata[DLY_AW-1:0];
                    default: ;
                endcase
            end
            if (pair_start)
                wgt_active <= wgt_stage;
        end
    end
endmodule

// File: rtl/rbf_cmul.sv
module rbf_cmul
    import rbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bb_cplx_t   x,
    input  logic       x_valid,
    input  wgt_t       w,
    output ring_cplx_t y,
    output logic       y_valid
);
    logic signed [PROD_W-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [PROD_W-1:0] acc_re, acc_im;

    always_comb begin
        p_rr   = PROD_W'(w.re) * PROD_W'(x.re);
        p_ii   = PROD_W'(w.im) * PROD_W'(x.im);
        p_ri   = PROD_W'(w.re) * PROD_W'(x.im);
        p_ir   = PROD_W'(w.im) * PROD_W'(x.re);
        acc_re = p_rr - p_ii;
        acc_im = p_ri + p_ir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= x_valid;
            if (x_valid) begin
                y.re <= round_prod(acc_re);
                y.im <= round_prod(acc_im);
            end
        end
    end
endmodule

// File: rtl/rbf_align.sv
module rbf_align
    import rbf_pkg::*;
#(
    parameter int DLY_DEPTH = 16,
    localparam int DLY_AW   = (DLY_DEPTH > 1) ? $clog2(DLY_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ring_cplx_t        in_data,
    input  logic              in_valid,
    input  logic [DLY_AW-1:0] align,
    output ring_cplx_t        out_data,
    output logic              out_valid
);
    ring_cplx_t line_d [DLY_DEPTH];
    logic       line_v [DLY_DEPTH];

    assign line_d[0] = in_data;
    assign line_v[0] = in_valid;

    generate
        for (genvar k = 1; k < DLY_DEPTH; k++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_v[k] <= 1'b0;
                    line_d[k] <= '0;
                end else begin
                    line_v[k] <= line_v[k-1];
                    line_d[k] <= line_d[k-1];
                end
            end
        end
    endgenerate

    assign out_data  = line_d[align];
    assign out_valid = line_v[align];
endmodule

// File: rtl/rbf_unit.sv
module rbf_unit
    import rbf_pkg::*;
#(
    parameter int CORR_W    = 16,
    parameter int DLY_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_valid,
    input  logic [SMP_W-1:0]  adc_data,
    input  logic              ring_in_valid,
    input  logic [RING_W-1:0] ring_in_re,
    input  logic [RING_W-1:0] ring_in_im,
    output logic              ring_out_valid,
    output logic [RING_W-1:0] ring_out_re,
    output logic [RING_W-1:0] ring_out_im,
    output logic              fb_valid,
    output logic [RING_W-1:0] fb_re,
    output logic [RING_W-1:0] fb_im,
    input  logic              corr_in_valid,
    input  logic [CORR_W-1:0] corr_in_data,
    output logic              corr_out_valid,
    output logic [CORR_W-1:0] corr_out_data,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [WGT_W-1:0]  cfg_wdata
);
    localparam int RING_LAT = 2;
    localparam int DLY_AW   = (DLY_DEPTH > 1) ? $clog2(DLY_DEPTH) : 1;

    logic              pair_start;
    bb_cplx_t          bb_data;
    logic              bb_valid;
    wgt_t              wgt_active;
    logic              head, tap_ring;
    logic [DLY_AW-1:0] align;
    ring_cplx_t        prod;
    logic              prod_valid;
    ring_cplx_t        loc_al;
    logic              loc_al_valid;

    rbf_ddc u_ddc (
        .clk(clk), .rst(rst),
        .adc_valid(adc_valid), .adc_data(adc_data),
        .pair_start(pair_start), .bb_data(bb_data), .bb_valid(bb_valid)
    );

    rbf_cfg #(.DLY_DEPTH(DLY_DEPTH)) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pair_start(pair_start), .wgt_active(wgt_active),
        .head(head), .tap_ring(tap_ring), .align(align)
    );

    rbf_cmul u_cmul (
        .clk(clk), .rst(rst),
        .x(bb_data), .x_valid(bb_valid), .w(wgt_active),
        .y(prod), .y_valid(prod_valid)
    );

    rbf_align #(.DLY_DEPTH(DLY_DEPTH)) u_align (
        .clk(clk), .rst(rst),
        .in_data(prod), .in_valid(prod_valid), .align(align),
        .out_data(loc_al), .out_valid(loc_al_valid)
    );

    // Stage 1: capture the partial sum and the aligned local sample.
    ring_cplx_t ring_s1, loc_s1;
    logic       ring_s1_v, loc_s1_v, head_s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_s1   <= '0;
            ring_s1_v <= 1'b0;
            loc_s1    <= '0;
            loc_s1_v  <= 1'b0;
            head_s1   <= 1'b0;
        end else begin
            ring_s1_v <= ring_in_valid && !head;
            ring_s1   <= (ring_in_valid && !head) ? {ring_in_re, ring_in_im} : '0;
            loc_s1_v  <= loc_al_valid;
            loc_s1    <= loc_al_valid ? loc_al : '0;
            head_s1   <= head;
        end
    end

    // Stage 2: saturating add and the filterbank source mux.
    ring_cplx_t sum_s2;
    logic       sum_s2_v;

    always_comb begin
        sum_s2.re = sat_add(ring_s1.re, loc_s1.re);
        sum_s2.im = sat_add(ring_s1.im, loc_s1.im);
        sum_s2_v  = head_s1 ? loc_s1_v : ring_s1_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_out_valid <= 1'b0;
            ring_out_re    <= '0;
            ring_out_im    <= '0;
            fb_valid       <= 1'b0;
            fb_re          <= '0;
            fb_im          <= '0;
        end else begin
            ring_out_valid <= sum_s2_v;
            ring_out_re    <= sum_s2.re;
            ring_out_im    <= sum_s2.im;
            if (tap_ring) begin
                fb_valid <= sum_s2_v;
                fb_re    <= sum_s2.re;
                fb_im    <= sum_s2.im;
            end else begin
                fb_valid <= loc_s1_v;
                fb_re    <= loc_s1.re;
                fb_im    <= loc_s1.im;
            end
        end
    end

    // Correlator lane: matched-latency pass-through.
    generate
        for (genvar i = 0; i < RING_LAT; i++) begin : g_corr
            logic              v_q;
            logic [CORR_W-1:0] d_q;
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        v_q <= 1'b0;
                        d_q <= '0;
                    end else begin
                        v_q <= corr_in_valid;
                        d_q <= corr_in_data;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        v_q <= 1'b0;
                        d_q <= '0;
                    end else begin
                        v_q <= g_corr[i-1].v_q;
                        d_q <= g_corr[i-1].d_q;
                    end
                end
            end
        end
    endgenerate

    assign corr_out_valid = g_corr[RING_LAT-1].v_q;
    assign corr_out_data  = g_corr[RING_LAT-1].d_q;
endmodule

// File: rtl/rbf_unit_checker.sv
module rbf_unit_checker #(
    parameter int CORR_W = 16,
    parameter int WGT_W2 = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bb_valid,
    input logic              pair_start,
    input logic [WGT_W2-1:0] wgt_bits,
    input logic              head,
    input logic              tap_ring,
    input logic              ring_in_valid,
    input logic              ring_out_valid,
    input logic              fb_valid,
    input logic              corr_in_valid,
    input logic [CORR_W-1:0] corr_in_data,
    input logic              corr_out_valid,
    input logic [CORR_W-1:0] corr_out_data
);
    a_r1_half_rate: assert property (@(posedge clk) disable iff (rst)
        bb_valid |=> !bb_valid);

    a_r5_tap_follows_ring: assert property (@(posedge clk) disable iff (rst)
        tap_ring |=> (fb_valid == ring_out_valid));

    a_r6_corr_pass: assert property (@(posedge clk) disable iff (rst)
        corr_in_valid |=> ##1 (corr_out_valid && corr_out_data == $past(corr_in_data, 2)));

    a_r7_weight_hold: assert property (@(posedge clk) disable iff (rst)
        !pair_start |=> $stable(wgt_bits));

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ring_out_valid && !fb_valid && !corr_out_valid));

    a_r10_ring_latency: assert property (@(posedge clk) disable iff (rst)
        (ring_in_valid && !head) |=> ##1 ring_out_valid);
endmodule

bind rbf_unit rbf_unit_checker #(.CORR_W(CORR_W), .WGT_W2(2*rbf_pkg::WGT_W)) u_chk (
    .clk(clk), .rst(rst),
    .bb_valid(bb_valid), .pair_start(pair_start), .wgt_bits(wgt_active),
    .head(head), .tap_ring(tap_ring),
    .ring_in_valid(ring_in_valid), .ring_out_valid(ring_out_valid), .fb_valid(fb_valid),
    .corr_in_valid(corr_in_valid), .corr_in_data(corr_in_data),
    .corr_out_valid(corr_out_valid), .corr_out_data(corr_out_data)
);

// File: tb/rbf_unit_bench.sv
module rbf_unit_bench;
    localparam int CW = 16;
    localparam int DD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_data = '0;
    logic        ring_in_valid = 1'b0;
    logic [23:0] ring_in_re = '0, ring_in_im = '0;
    logic        ring_out_valid, fb_valid, corr_out_valid;
    logic [23:0] ring_out_re, ring_out_im, fb_re, fb_im;
    logic        corr_in_valid = 1'b0;
    logic [CW-1:0] corr_in_data = '0, corr_out_data;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;

    always #2 clk = ~clk;

    rbf_unit #(.CORR_W(CW), .DLY_DEPTH(DD)) u_rbf_unit (
        .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data),
        .ring_in_valid(ring_in_valid), .ring_in_re(ring_in_re), .ring_in_im(ring_in_im),
        .ring_out_valid(ring_out_valid), .ring_out_re(ring_out_re), .ring_out_im(ring_out_im),
        .fb_valid(fb_valid), .fb_re(fb_re), .fb_im(fb_im),
        .corr_in_valid(corr_in_valid), .corr_in_data(corr_in_data),
        .corr_out_valid(corr_out_valid), .corr_out_data(corr_out_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    int n_chk = 0, n_fail = 0;

    typedef struct { logic [47:0] v; string req; } exp_t;
    exp_t q_ring[$], q_fb[$], q_corr[$];

    task automatic check(string req, logic [47:0] act, logic [47:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic pop_cmp(ref exp_t q[$], input logic [47:0] act, input string lane);
        exp_t e;
        if (q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R10 unexpected %s output actual=%h expected=none", lane, act);
        end else begin
            e = q.pop_front();
            check(e.req, act, e.v);
        end
    endtask

    // Monitor: compare outputs away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (ring_out_valid) pop_cmp(q_ring, {ring_out_re, ring_out_im}, "ring");
            if (fb_valid)       pop_cmp(q_fb, {fb_re, fb_im}, "filterbank");
            if (corr_out_valid) pop_cmp(q_corr, {32'd0, corr_out_data}, "correlator");
        end
    end

    // Bench model state
    int m_wre = 0, m_wim = 0, m_head = 0, m_tap = 0, m_dly = 0, m_pair = 0;

    function automatic longint rnd(longint p);
        return (p + 1024) >>> 11;
    endfunction
    function automatic longint sat(longint s);
        if (s > 8388607) return 8388607;
        if (s < -8388608) return -8388608;
        return s;
    endfunction
    function automatic int gen(int k, int seed);
        return ((((k + 1) * seed * 1103) + 12345 * seed) & 4095) - 2048;
    endfunction

    // Per-cycle schedule
    bit s_av[64], s_rv[64], s_cv[64], s_we[64];
    int s_ad[64], s_rre[64], s_rim[64], s_cd[64], s_wa[64], s_wd[64];

    task automatic play(int ncyc);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            adc_valid     = s_av[c];  adc_data   = 12'(s_ad[c]);
            ring_in_valid = s_rv[c];  ring_in_re = 24'(s_rre[c]); ring_in_im = 24'(s_rim[c]);
            corr_in_valid = s_cv[c];  corr_in_data = CW'(s_cd[c]);
            cfg_we        = s_we[c];  cfg_addr   = 2'(s_wa[c]);   cfg_wdata = 12'(s_wd[c]);
        end
        @(negedge clk);
        adc_valid = 0; ring_in_valid = 0; corr_in_valid = 0; cfg_we = 0;
        repeat (DD + 8) @(negedge clk);
    endtask

    task automatic cfg_write(int a, int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 12'(d);
        @(negedge clk);
        cfg_we = 0;
        case (a)
            0: m_wre = d;
            1: m_wim = d;
            2: begin m_head = d & 1; m_tap = (d >> 1) & 1; end
            default: m_dly = (d > DD - 1) ? DD - 1 : d;
        endcase
        repeat (2) @(negedge clk);
    endtask

    // ring_mode 0: moderate sums, 1: near full scale. wcyc >= 0 schedules a weight write.
    task automatic burst(int np, int seed, int ring_mode, int wcyc, int nwre, int nwim, string tag);
        int last;
        for (int c = 0; c < 64; c++) begin
            s_av[c] = 0; s_rv[c] = 0; s_cv[c] = 0; s_we[c] = 0;
            s_ad[c] = 0; s_rre[c] = 0; s_rim[c] = 0; s_cd[c] = 0; s_wa[c] = 0; s_wd[c] = 0;
        end
        if (wcyc >= 0) begin
            s_we[wcyc] = 1; s_wa[wcyc] = 0; s_wd[wcyc] = nwre;
            s_we[wcyc+1] = 1; s_wa[wcyc+1] = 1; s_wd[wcyc+1] = nwim;
        end
        last = 0;
        for (int k = 0; k < np; k++) begin
            int s, x0, x1, xi, xq, wr, wi, rr, ri, rc;
            longint lre, lim, ore, oim;
            s  = 2 * k;
            x0 = gen(2 * k, seed);
            x1 = gen(2 * k + 1, seed);
            s_av[s] = 1; s_ad[s] = x0; s_av[s+1] = 1; s_ad[s+1] = x1;
            // R1: mixing phase follows the pair count since reset
            if ((m_pair % 2) == 0) begin xi = x0;  xq = -x1; end
            else                   begin xi = -x0; xq = x1;  end
            m_pair++;
            // R7: writes issued before the pair's first sample apply
            wr = (wcyc >= 0 && wcyc < s)     ? nwre : m_wre;
            wi = (wcyc >= 0 && wcyc + 1 < s) ? nwim : m_wim;
            if (wr > 2047) wr -= 4096;
            if (wi > 2047) wi -= 4096;
            lre = rnd(longint'(wr) * xi - longint'(wi) * xq);
            lim = rnd(longint'(wr) * xq + longint'(wi) * xi);
            if (ring_mode == 1) begin
                rr = (k % 2 == 0) ? 8388607 - 10 * k : -8388608 + 10 * k;
                ri = -rr - 1;
            end else begin
                rr = gen(k, seed + 1) * 97;
                ri = gen(k, seed + 2) * 55;
            end
            s_rv[s+3+m_dly] = 1; s_rre[s+3+m_dly] = rr; s_rim[s+3+m_dly] = ri;
            if (m_head != 0) begin ore = lre; oim = lim; end
            else begin ore = sat(rr + lre); oim = sat(ri + lim); end
            q_ring.push_back('{ {24'(ore), 24'(oim)}, {tag, " R3 R10 ring sum"} });
            if (m_tap != 0) q_fb.push_back('{ {24'(ore), 24'(oim)}, {tag, " R5 tap ring"} });
            else            q_fb.push_back('{ {24'(lre), 24'(lim)}, {tag, " R1 R2 R5 tap local"} });
            rc = gen(k, seed + 5) & 16'hFFFF;
            s_cv[s] = 1; s_cd[s] = rc;
            q_corr.push_back('{ {32'd0, CW'(rc)}, "R6 correlator lane" });
            last = s + 3 + m_dly;
        end
        if (wcyc >= 0) begin m_wre = nwre; m_wim = nwim; end
        play(last + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 ring valid in reset", {47'd0, ring_out_valid}, 48'd0);
        rst = 0;
        @(negedge clk);
        check("R9 ring valid after reset", {47'd0, ring_out_valid}, 48'd0);
        check("R9 fb valid after reset", {47'd0, fb_valid}, 48'd0);
        check("R9 corr valid after reset", {47'd0, corr_out_valid}, 48'd0);

        // R9: cleared weights pass the ring sum through unchanged, local port shows zero
        burst(4, 3, 0, -1, 0, 0, "R9");

        // R1 R2 R10: real weight, tap on ring sum
        cfg_write(0, 1024); cfg_write(1, 0); cfg_write(2, 2);
        burst(6, 5, 0, -1, 0, 0, "R1 R2");

        // R2 R5 R8: complex weight, local tap, delay of 2
        cfg_write(0, -1500 & 4095); cfg_write(1, 700); cfg_write(2, 0); cfg_write(3, 2);
        burst(6, 7, 0, -1, 0, 0, "R2 R8");

        // R3: saturation at both limits
        cfg_write(0, 2047); cfg_write(1, 2047); cfg_write(2, 2); cfg_write(3, 0);
        burst(8, 11, 1, -1, 0, 0, "R3 saturate");

        // R4: head ignores the ring input
        cfg_write(2, 3); cfg_write(0, 900); cfg_write(1, -333 & 4095);
        burst(5, 13, 0, -1, 0, 0, "R4 head");

        // R7: weight write landing between the samples of a pair
        cfg_write(2, 2);
        burst(6, 17, 0, 5, -800 & 4095, 1200, "R7 weight boundary");

        // R8: out-of-range delay clamps to DLY_DEPTH-1
        cfg_write(3, 20);
        burst(6, 19, 0, -1, 0, 0, "R8 delay clamp");

        check("R10 ring queue drained", 48'(q_ring.size()), 48'd0);
        check("R5 fb queue drained", 48'(q_fb.size()), 48'd0);
        check("R6 corr queue drained", 48'(q_corr.size()), 48'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule